// File: doc/BRIEF.md
# Configurable Timebase Prescaler Counter

This block keeps a free-running 16-bit time-base count for a timer subsystem. The count does not advance on every system clock. It advances on an enable that a two-stage divider produces. The first stage is a coarse divider that divides by 32 or by 4. The second stage divides the first stage's output again by 1, 2, 4 or 8. A separate fast bit replaces the whole chain with a fixed divide-by-two rate. The block shows the running count on an output and raises a one-clock tick in the same cycle that each new count value appears.

Software writes the three control fields through a small word-wide register bus. The bus accepts a request in every cycle and has no back-pressure: a request is one cycle with `bus_valid` high, and its response (`bus_resp`, `bus_rdata`, `bus_err`) appears in the next cycle. A written setting is held as pending. It moves into the divider only at a divider terminal count, so a period that has already started finishes at its old length.

Top module: `tbase_counter`

## Requirements
- R1: After reset the count is 0, tick is low, the control word reads 0, and the count advances once every 32 clocks.
- R2: With the fast bit (bit 0 of the control word at word address 0) set to 1, the count advances once every 2 clocks, whatever the other fields hold.
- R3: With the fast bit at 0 and the coarse bit (bit 1) at 0, the period is 32, 64, 128 or 256 clocks for a rate code (bits 3:2) of 0, 1, 2 or 3.
- R4: With the fast bit at 0 and the coarse bit at 1, the period is 4, 8, 16 or 32 clocks for a rate code of 0, 1, 2 or 3.
- R5: Tick is high for exactly one clock per advance, the count is one higher in that same cycle, and the count wraps from 0xFFFF to 0x0000.
- R6: A new setting first applies to the period that starts at the next terminal count, and the period in progress finishes at its old length. A write accepted on the clock edge of a terminal count applies to the period that starts on that edge.
- R7: A read of word address 0 returns the control fields in bits 3:0 with all upper bits zero, one cycle after the request, and `bus_resp` is high for every request in that following cycle.
- R8: A read of any word address other than 0 returns zero, and a write to such an address leaves the control word unchanged.
- R9: Any access that does not enable both byte lanes (`bus_be` other than 2'b11) raises `bus_err` with its response, returns zero data, and, if it is a write, leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address within the register window |
| bus_be | input | 2 | Byte-lane enables; only 2'b11 is a legal access |
| bus_wdata | input | 16 | Write data |
| bus_resp | output | 1 | Response strobe, one cycle after each request |
| bus_rdata | output | 16 | Read data returned with the response |
| bus_err | output | 1 | Partial-width access flag returned with the response |
| count | output | 16 | Current time-base count |
| tick | output | 1 | One-clock pulse in the cycle the count advances |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge, and that every input is stable and defined around each rising edge. Nothing is assumed about how often requests arrive, because the bus has no back-pressure and the response rule must hold even when requests come in consecutive cycles. The stimulus drives inputs one nanosecond after each rising edge and keeps each request to exactly one cycle. Random control words, byte-lane patterns and unused addresses are all legal inputs, so they need no filtering. Directed writes are placed on chosen cycles relative to a terminal count to exercise the cases that come before, on and after the terminal edge.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  // Rate-code width; the post-divider spans 2**(2**POST_W - 1).
  localparam int POST_W   = 2;
  localparam int CFG_W    = POST_W + 2;
  localparam int CFG_ADDR = 0;

  // Bit 0 = fast, bit 1 = coarse select, bits [CFG_W-1:2] = rate code.
  typedef struct packed {
    logic [POST_W-1:0] post;
    logic              pre;
    logic              fast;
  } tbase_cfg_t;
endpackage

// File: rtl/tbase_divstage.sv
module tbase_divstage #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = step && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  // R6
  stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
  import tbase_pkg::*;
#(
  parameter int PRE_SLOW = 32,
  parameter int PRE_FAST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tbase_cfg_t cfg_next,
  output logic       term
);
  localparam int S1_W     = $clog2(PRE_SLOW);
  localparam int POST_MAX = 1 << ((1 << POST_W) - 1);
  localparam int S2_W     = (POST_MAX > 1) ? $clog2(POST_MAX) : 1;

  tbase_cfg_t      cfg_act;
  logic [S1_W-1:0] s1_last;
  logic [S2_W-1:0] s2_last;
  logic            s1_wrap;

  always_comb begin
    if (cfg_act.fast)     s1_last = S1_W'(1);
    else if (cfg_act.pre) s1_last = S1_W'(PRE_FAST - 1);
    else                  s1_last = S1_W'(PRE_SLOW - 1);
    if (cfg_act.fast)     s2_last = '0;
    else                  s2_last = S2_W'((32'd1 << cfg_act.post) - 32'd1);
  end

  tbase_divstage #(.W(S1_W)) u_coarse (
    .clk  (clk),
    .rst_n(rst_n),
    .step (1'b1),
    .last (s1_last),
    .wrap (s1_wrap)
  );

  tbase_divstage #(.W(S2_W)) u_fine (
    .clk  (clk),
    .rst_n(rst_n),
    .step (s1_wrap),
    .last (s2_last),
    .wrap (term)
  );

  // Settings move in only at a terminal count, so no period is cut short.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_act <= '0;
    else if (term) cfg_act <= cfg_next;
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(cfg_act));

  // R2
  fast_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.fast && !term) |=> term);
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_resp,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output tbase_cfg_t        cfg_next
);
  tbase_cfg_t       cfg_q;
  logic             full_word;
  logic             hit;
  logic             wr_ok;
  logic             rd_ok;
  logic [CFG_W-1:0] cfg_bits;
  logic             wdata_unused;

  assign full_word    = &bus_be;
  assign hit          = (bus_addr == ADDR_W'(CFG_ADDR));
  assign wr_ok        = bus_valid && bus_write && full_word && hit;
  assign rd_ok        = bus_valid && !bus_write && full_word && hit;
  assign cfg_bits     = cfg_q;
  assign wdata_unused = ^bus_wdata[DATA_W-1:CFG_W];

  // Next value is exposed so a write on a terminal edge is forwarded.
  assign cfg_next = wr_ok ? tbase_cfg_t'(bus_wdata[CFG_W-1:0]) : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      bus_resp  <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      cfg_q     <= cfg_next;
      bus_resp  <= bus_valid;
      bus_err   <= bus_valid && !full_word;
      bus_rdata <= rd_ok ? {{(DATA_W-CFG_W){1'b0}}, cfg_bits} : '0;
    end
  end

  // R7
  resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> bus_resp);

  // R9
  partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !full_word) |=> $stable(cfg_q));

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_resp && bus_rdata == '0));

  // R8
  unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !hit) |=> $stable(cfg_q));
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int PRE_SLOW = 32,
  parameter int PRE_FAST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_resp,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  output logic [CNT_W-1:0]    count,
  output logic                tick
);
  tbase_cfg_t cfg_next;
  logic       term;

  tbase_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .bus_wdata(bus_wdata),
    .bus_resp (bus_resp),
    .bus_rdata(bus_rdata),
    .bus_err  (bus_err),
    .cfg_next (cfg_next)
  );

  tbase_prescaler #(.PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_next(cfg_next),
    .term    (term)
  );

  // Count and tick change on the same edge, so tick marks the new value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= term;
      if (term) count <= count + 1'b1;
    end
  end

  // R5
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (count == CNT_W'($past(count) + 1'b1)));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> $stable(count));
endmodule

// File: tb/tbase_counter_tb.sv
module tbase_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_resp;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [15:0] count;
  logic        tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tick_n = 0;
  int last_tick_cyc = 0;
  int last_interval = 0;
  int mism = 0;
  logic [15:0] prev_count = '0;
  logic prev_tick = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  tbase_counter u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_resp(bus_resp), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .count(count), .tick(tick)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Tick monitor: period measurement and per-advance count check (R5).
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick) begin
        last_interval = cyc - last_tick_cyc;
        last_tick_cyc = cyc;
        tick_n++;
        if (count != 16'(prev_count + 16'd1)) mism++;
        if (prev_tick) mism++;
        prev_count = count;
      end
      prev_tick = tick;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic xfer(input bit wr, input logic [2:0] a, input logic [1:0] be,
                      input logic [15:0] wd, output logic [15:0] rd,
                      output logic er, output logic rs);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; bus_be = '0;
    rd = bus_rdata; er = bus_err; rs = bus_resp;
  endtask

  task automatic wr_cfg(input logic [15:0] wd);
    logic [15:0] rd; logic er, rs;
    xfer(1'b1, 3'd0, 2'b11, wd, rd, er, rs);
  endtask

  task automatic rd_word(input logic [2:0] a, output logic [15:0] rd);
    logic er, rs;
    xfer(1'b0, a, 2'b11, 16'h0, rd, er, rs);
  endtask

  task automatic wait_ticks(input int n);
    int t0 = tick_n;
    while (tick_n < t0 + n) begin @(posedge clk); #1; end
  endtask

  function automatic int exp_period(input bit f, input bit p, input int q);
    if (f) return 2;
    return (p ? 4 : 32) << q;
  endfunction

  function automatic logic [15:0] enc(input bit f, input bit p, input int q);
    return {12'h0, 2'(q), p, f};
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, 0);
      report();
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic er, rs;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check(count == 16'h0, "R1 count", count, 0);
    check(tick == 1'b0, "R1 tick", tick, 0);
    rd_word(3'd0, rd);
    check(rd == 16'h0, "R1 cfg readback", rd, 0);
    wait_ticks(2);
    check(last_interval == 32, "R1 default period", last_interval, 32);

    // R3 coarse /32 rates, R4 coarse /4 rates
    for (int p = 0; p < 2; p++) begin
      for (int q = 0; q < 4; q++) begin
        wr_cfg(enc(1'b0, p[0], q));
        wait_ticks(1); wait_ticks(1);
        check(last_interval == exp_period(1'b0, p[0], q), p ? "R4 period" : "R3 period",
              last_interval, exp_period(1'b0, p[0], q));
      end
    end

    // R2 fast overrides other fields
    wr_cfg(enc(1'b1, 1'b0, 3));
    wait_ticks(1); wait_ticks(1);
    check(last_interval == 2, "R2 fast period", last_interval, 2);

    // R7 readback masks upper bits
    wr_cfg(16'hFFF6);
    rd_word(3'd0, rd);
    check(rd == 16'h0006, "R7 readback", rd, 6);
    xfer(1'b0, 3'd0, 2'b11, 16'h0, rd, er, rs);
    check(rs == 1'b1 && er == 1'b0, "R7 resp", {rs, er}, 2);

    // R8 unused addresses
    xfer(1'b1, 3'd5, 2'b11, 16'h000F, rd, er, rs);
    rd_word(3'd0, rd);
    check(rd == 16'h0006, "R8 unused write", rd, 6);
    rd_word(3'd3, rd);
    check(rd == 16'h0, "R8 unused read", rd, 0);

    // R9 partial accesses
    xfer(1'b1, 3'd0, 2'b01, 16'h0009, rd, er, rs);
    check(er == 1'b1 && rs == 1'b1, "R9 write err", er, 1);
    rd_word(3'd0, rd);
    check(rd == 16'h0006, "R9 write ignored", rd, 6);
    xfer(1'b0, 3'd0, 2'b10, 16'h0, rd, er, rs);
    check(er == 1'b1 && rd == 16'h0, "R9 read err/zero", rd, 0);

    // R6 mid-period change: old period finishes, then new one applies
    wr_cfg(enc(1'b0, 1'b0, 3));
    wait_ticks(1); wait_ticks(1);
    repeat (10) begin @(posedge clk); #1; end
    wr_cfg(enc(1'b0, 1'b1, 0));
    wait_ticks(1);
    check(last_interval == 256, "R6 old period kept", last_interval, 256);
    wait_ticks(1);
    check(last_interval == 4, "R6 new period", last_interval, 4);

    // R6 write landing on a terminal edge
    wr_cfg(enc(1'b0, 1'b1, 1));
    wait_ticks(1); wait_ticks(1);
    while (cyc != last_tick_cyc + 7) begin @(posedge clk); #1; end
    wr_cfg(enc(1'b0, 1'b1, 3));
    wait_ticks(1);
    check(last_interval == 8, "R6 edge old period", last_interval, 8);
    wait_ticks(1);
    check(last_interval == 32, "R6 edge new period", last_interval, 32);

    // Random configurations (R2 R3 R4 R7 R8)
    for (int i = 0; i < 10; i++) begin
      bit f = ($urandom % 4) == 0;
      bit p = $urandom % 2;
      int q = $urandom % 4;
      logic [15:0] hi = 16'($urandom) & 16'hFFF0;
      if ($urandom % 2) xfer(1'b1, 3'(1 + $urandom % 7), 2'b11, 16'($urandom), rd, er, rs);
      wr_cfg(hi | enc(f, p, q));
      rd_word(3'd0, rd);
      check(rd == enc(f, p, q), "R7 random readback", rd, enc(f, p, q));
      wait_ticks(1); wait_ticks(1);
      check(last_interval == exp_period(f, p, q), f ? "R2 random" : (p ? "R4 random" : "R3 random"),
            last_interval, exp_period(f, p, q));
    end

    // R5 wrap at fast rate
    wr_cfg(enc(1'b1, 1'b0, 0));
    while (count != 16'hFFFF) wait_ticks(1);
    wait_ticks(1);
    check(count == 16'h0000, "R5 wrap", count, 0);
    check(mism == 0, "R5 tick/count steps", mism, 0);

    done = 1;
    report();
    $finish;
  end
endmodule